// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers four shared, level-sensitive PCI interrupt request lines (pins A, B, C and D) onto sixteen interrupt controller inputs. Software programs it through a small byte-wide register window of three bytes at offsets 0x55, 0x56 and 0x57. Each pin takes a 4-bit routing code from a fixed nibble of that window. The code names the controller input that the pin drives, and code 0 leaves the pin unconnected. When several pins carry the same code, they share that input as a wired OR.

Controller inputs 2, 8 and 13 are reserved. When an asserted pin is routed to one of them, the block still drives the line, and it also sets a sticky configuration-error flag. Software clears the flag with a one-cycle strobe. The controller lines are registered, so every change reaches them one clock later. The block has no state machine. Its state is the register window, the registered line bank and the error flag.

Top module: `pirq_router`

## Requirements
- R1: After reset the three window bytes read 0x00, all sixteen `isa_irq` lines are low and `route_err` is low.
- R2: A write at offset 0x55, 0x56 or 0x57 stores the full byte, and a read there returns the full stored byte combinationally. A write at any other offset changes no stored byte, and a read at any other offset returns 0x00.
- R3: The routing code of pin A is bits 7:4 of offset 0x55. Pin B uses bits 3:0 of offset 0x56, pin C uses bits 7:4 of offset 0x56, and pin D uses bits 7:4 of offset 0x57. Bits 3:0 of offsets 0x55 and 0x57 have no effect on routing. `pci_int` bit 0 is pin A, bit 1 is B, bit 2 is C and bit 3 is D, and a 1 means asserted.
- R4: A routing code of 0 disables the pin. A disabled pin drives no line, and `isa_irq[0]` is never asserted.
- R5: Each line `isa_irq[n]` (n from 1 to 15) is the OR of every asserted pin whose routing code equals n. A line with no asserted pin routed to it is low.
- R6: `isa_irq` reflects the pin levels one clock edge after they change. After a window write, the new routing shows on `isa_irq` at the edge after the write edge.
- R7: At any edge where an asserted pin carries routing code 2, 8 or 13, `route_err` becomes 1. The reserved line is still driven high.
- R8: `route_err` stays at 1 until an edge where `err_clr` is high, and it clears at that edge. If an error condition is present at the same edge as the strobe, the set wins and the flag stays at 1.
- R9: A reserved code on a deasserted pin, or a non-reserved code on an asserted pin, does not set `route_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_addr | input | 8 | Byte offset for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| pci_int | input | 4 | PCI pin levels, bit 0 = A to bit 3 = D, 1 = asserted |
| err_clr | input | 1 | Clear strobe for the error flag |
| isa_irq | output | 16 | Registered controller input lines |
| route_err | output | 1 | Sticky reserved-routing flag |

## Verification
Read data is due in the same cycle as the offset, with no clock edge in between. Line levels and the error flag are due exactly one edge after the pin levels or error condition that cause them. A window write needs one edge to store the byte and a second edge before the new routing reaches the lines. The bench drives every input 1 ns after a rising edge and samples 1 ns after the next rising edge. It samples one edge later for pin effects and two edges later for routing changes, and it also checks the intermediate edge to confirm that the old routing is still present there.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int NUM_PINS  = 4;
    localparam int CODE_W    = 4;
    localparam int NUM_LINES = 1 << CODE_W;
    localparam int NUM_REGS  = 3;
    localparam int BYTE_W    = 8;

    typedef logic [CODE_W-1:0] code_t;

    // which window byte and which half carries each pin's code
    localparam int PIN_REG [NUM_PINS] = '{0, 1, 1, 2};
    localparam bit PIN_HI  [NUM_PINS] = '{1'b1, 1'b0, 1'b1, 1'b1};

    function automatic logic code_reserved(input code_t c);
        return (c == code_t'(2)) || (c == code_t'(8)) || (c == code_t'(13));
    endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output code_t             codes [NUM_PINS]
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        off    = addr - BASE;
        in_win = (addr >= BASE) && (off < ADDR_W'(NUM_REGS));
        idx    = off[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (we && in_win) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (idx == IDX_W'(i)) regs_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (in_win && idx == IDX_W'(i)) rdata = regs_q[i];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if (PIN_HI[p]) begin : g_hi
            assign codes[p] = regs_q[PIN_REG[p]][BYTE_W-1 -: CODE_W];
        end else begin : g_lo
            assign codes[p] = regs_q[PIN_REG[p]][CODE_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
        p_win_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && in_win && idx == IDX_W'(i)) |=> (regs_q[i] == $past(wdata)));
        p_off_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !in_win) |=> $stable(regs_q[i]));
    end
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge
    import pirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_lvl,
    input  code_t                codes [NUM_PINS],
    output logic [NUM_LINES-1:0] line_q,
    output logic                 rsv_hit
);
    logic [NUM_LINES-1:0] line_d;

    always_comb begin
        line_d  = '0;
        rsv_hit = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_lvl[p] && codes[p] != '0) line_d[codes[p]] = 1'b1;
            if (pin_lvl[p] && code_reserved(codes[p])) rsv_hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        p_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_lvl[p] && codes[p] != '0) |=> line_q[$past(codes[p])]);
    end

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl == '0) |=> (line_q == '0));
    p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (codes[0] == '0 && codes[1] == '0 && codes[2] == '0 && codes[3] == '0)
        |=> (line_q == '0));
endmodule

// File: rtl/pirq_err_flag.sv
module pirq_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [BYTE_W-1:0]    cfg_wdata,
    output logic [BYTE_W-1:0]    cfg_rdata,
    input  logic [NUM_PINS-1:0]  pci_int,
    input  logic                 err_clr,
    output logic [NUM_LINES-1:0] isa_irq,
    output logic                 route_err
);
    code_t codes [NUM_PINS];
    logic  rsv_hit;

    pirq_cfg_regs #(.ADDR_W(ADDR_W), .BASE(WIN_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .codes(codes)
    );

    pirq_merge u_merge (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pci_int), .codes(codes),
        .line_q(isa_irq), .rsv_hit(rsv_hit)
    );

    pirq_err_flag u_err (
        .clk(clk), .rst_n(rst_n), .set_i(rsv_hit), .clr_i(err_clr),
        .flag_o(route_err)
    );

    p_no_line0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_irq[0]);
    p_idle_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_int == '0 && err_clr) |=> !route_err);
endmodule

// File: tb/pirq_router_test.sv
module pirq_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_int = 4'h0;
    logic        err_clr = 1'b0;
    logic [15:0] isa_irq;
    logic        route_err;

    int total = 0;
    int bad = 0;
    logic [7:0] m [3];

    always #5 clk = ~clk;

    pirq_router uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_int(pci_int),
        .err_clr(err_clr), .isa_irq(isa_irq), .route_err(route_err)
    );

    function automatic logic [3:0] code_of(input int p);
        case (p)
            0:       return m[0][7:4];
            1:       return m[1][3:0];
            2:       return m[1][7:4];
            default: return m[2][7:4];
        endcase
    endfunction

    function automatic logic [15:0] exp_lines(input logic [3:0] pins);
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (pins[p] && code_of(p) != 4'd0) r[code_of(p)] = 1'b1;
        return r;
    endfunction

    function automatic logic exp_hit(input logic [3:0] pins);
        logic h = 1'b0;
        for (int p = 0; p < 4; p++)
            if (pins[p] && (code_of(p) == 4'd2 || code_of(p) == 4'd8 || code_of(p) == 4'd13))
                h = 1'b1;
        return h;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a >= 8'h55 && a <= 8'h57) return m[a - 8'h55];
        return 8'h00;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
        if (a >= 8'h55 && a <= 8'h57) m[a - 8'h55] = d;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        cfg_addr = a;
        #1;
        chk(tag, {24'd0, cfg_rdata}, {24'd0, exp_read(a)});
    endtask

    // program routing with pins idle, then apply pins for one edge
    task automatic route_and_drive(input logic [7:0] b0, input logic [7:0] b1,
                                   input logic [7:0] b2, input logic [3:0] pins);
        pci_int = 4'h0;
        err_clr = 1'b1;
        wr(8'h55, b0); wr(8'h56, b1); wr(8'h57, b2);
        err_clr = 1'b0;
        pci_int = pins;
        step();
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m[i] = 8'h00;
        void'($urandom(32'd20230216));
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 lines", {16'd0, isa_irq}, 32'd0);
        chk("R1 err", {31'd0, route_err}, 32'd0);
        rd_chk("R1 read55", 8'h55);
        rd_chk("R1 read57", 8'h57);

        // R2 window access
        wr(8'h55, 8'hA7);
        rd_chk("R2 read55", 8'h55);
        wr(8'h54, 8'hFF);
        wr(8'h58, 8'hEE);
        rd_chk("R2 read54 zero", 8'h54);
        rd_chk("R2 read58 zero", 8'h58);
        rd_chk("R2 55 kept", 8'h55);
        rd_chk("R2 56 kept", 8'h56);

        // R3/R4 low nibbles of 0x55/0x57 do nothing; code 0 disables
        route_and_drive(8'h07, 8'h00, 8'h09, 4'hF);
        chk("R3 R4 low nibbles unused", {16'd0, isa_irq}, 32'd0);
        route_and_drive(8'h00, 8'h3C, 8'h00, 4'h2);
        chk("R3 pin B low nibble", {16'd0, isa_irq}, 32'h1000);
        route_and_drive(8'h00, 8'h3C, 8'h00, 4'h4);
        chk("R3 pin C high nibble", {16'd0, isa_irq}, 32'h0008);
        route_and_drive(8'h10, 8'h00, 8'hF0, 4'h9);
        chk("R3 pins A D", {16'd0, isa_irq}, 32'h8002);

        // R5 shared line OR
        route_and_drive(8'hB0, 8'hBB, 8'hB0, 4'h5);
        chk("R5 shared line", {16'd0, isa_irq}, 32'h0800);
        pci_int = 4'h8; step();
        chk("R5 single source", {16'd0, isa_irq}, 32'h0800);
        pci_int = 4'h0; step();
        chk("R5 no source", {16'd0, isa_irq}, 32'd0);

        // R6 timing
        route_and_drive(8'h50, 8'h00, 8'h00, 4'h1);
        chk("R6 pin one edge", {16'd0, isa_irq}, 32'h0020);
        cfg_we = 1'b1; cfg_addr = 8'h55; cfg_wdata = 8'h60;
        step();
        cfg_we = 1'b0; m[0] = 8'h60;
        chk("R6 old routing at write edge", {16'd0, isa_irq}, 32'h0020);
        step();
        chk("R6 new routing next edge", {16'd0, isa_irq}, 32'h0040);
        pci_int = 4'h0; step();
        chk("R6 pin release", {16'd0, isa_irq}, 32'd0);

        // R7 reserved code sets flag, line still driven
        route_and_drive(8'h80, 8'h00, 8'h00, 4'h1);
        chk("R7 reserved line", {16'd0, isa_irq}, 32'h0100);
        chk("R7 err set", {31'd0, route_err}, 32'd1);

        // R8 sticky and clear
        pci_int = 4'h0; step(); step();
        chk("R8 sticky", {31'd0, route_err}, 32'd1);
        pci_int = 4'h1; err_clr = 1'b1; step();
        chk("R8 set beats clear", {31'd0, route_err}, 32'd1);
        pci_int = 4'h0; step();
        err_clr = 1'b0;
        chk("R8 cleared", {31'd0, route_err}, 32'd0);

        // R9 no false error
        route_and_drive(8'h00, 8'h0D, 8'h00, 4'hD);
        chk("R9 reserved but idle", {31'd0, route_err}, 32'd0);
        route_and_drive(8'hE0, 8'h9F, 8'h30, 4'hF);
        chk("R9 non-reserved", {31'd0, route_err}, 32'd0);
        chk("R5 mixed lines", {16'd0, isa_irq}, {16'd0, exp_lines(4'hF)});

        // random routing and pins
        for (int it = 0; it < 300; it++) begin
            logic [3:0] pins;
            logic [7:0] b0, b1, b2, ra;
            b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
            pins = 4'($urandom);
            route_and_drive(b0, b1, b2, pins);
            chk("R5 random lines", {16'd0, isa_irq}, {16'd0, exp_lines(pins)});
            chk("R7 R9 random err", {31'd0, route_err}, {31'd0, exp_hit(pins)});
            ra = (it % 2 == 0) ? 8'(8'h55 + it % 3) : 8'($urandom);
            rd_chk("R2 random read", ra);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule